// File: doc/BRIEF.md
# Interrupt Vector Receiver

This block sits beside a processor core and turns a set of level-sensitive interrupt vector lines into a pending hard interrupt. A rising level on any line latches that line's number into a formatted incoming data word, marks the receive register busy, raises priority-level bit 5 and the hard interrupt request, and selects the interrupt-vector trap type. A falling level on any line withdraws the request and clears the busy mark.

Software reads the receive status and the three incoming data words through a small alternate-space load/store port. Stores to the receive status space write the register masked down to the busy bit, so software clears the busy mark by storing zero. Each input line is watched for edges against the line level seen in the previous cycle. A line held high therefore raises the request only once.

Top module: `intr_vec_receiver`

## Requirements
- R1: After reset the receive status, all three data words, the hard interrupt request, every priority-level bit and the trap type output are zero.
- R2: A rising level on input line n makes the receive status read 0x20 (bit 5 set) from the next cycle on. It also loads data word 0 with 0x7C0 | n, which is 0x1F in bits 10:6 and n in bits 5:0, and loads data words 1 and 2 with zero.
- R3: A rise also drives the hard interrupt request high and sets priority-level bit 5, with all other priority-level bits staying zero. It sets the trap type output to 0x060, and that value is held until reset.
- R4: When several lines rise in the same cycle, the lowest-numbered rising line is the one captured in data word 0.
- R5: A rise while the busy bit is already set overwrites data word 0 with the new line number.
- R6: A falling level on any line, in a cycle with no rise, clears status bit 5, priority-level bit 5 and the hard interrupt request on the next cycle, and leaves the data words unchanged. If a rise happens in the same cycle, the rise takes effect.
- R7: A load (asi_we = 0) from space 0x49 returns the receive status register.
- R8: A store to space 0x49 writes the status register with the store data ANDed with 0x20 and does not touch the interrupt request. The store is dropped in a cycle where any line rises or falls.
- R9: A load from space 0x7F returns data word (addr >> 4) & 3. Index 3 returns zero.
- R10: A load from space 0x48, or from any other space, returns zero. Stores to spaces 0x48 and 0x7F change nothing.
- R11: A line held high does not raise again. After software clears the status, it stays clear and the request stays asserted until an edge arrives.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| vec_lvl | input | NUM_VEC | Interrupt vector line levels |
| asi_valid | input | 1 | Alternate-space access request |
| asi_we | input | 1 | 1 = store, 0 = load |
| asi_space | input | 8 | Alternate space identifier |
| asi_addr | input | ADDR_W | Access address |
| asi_wdata | input | 64 | Store data |
| asi_rdata | output | 64 | Load data (combinational) |
| irq_req | output | 1 | Hard interrupt request |
| pil_level | output | PIL_W | Priority-level input bits |
| trap_type | output | TRAP_W | Selected trap type |

## Verification
The checker keeps its own registered copy of the line levels, which is cleared by reset just as the design's copy is. Its edge-based properties therefore assume that the lines are low while reset is held. The bench drives every line low during reset and changes lines and store requests only on falling clock edges, so each edge and each store lands in a single cycle. Cycles where a store and an edge coincide are driven on purpose, to exercise the rise-over-fall-over-store ordering.

// File: rtl/ivr_pkg.sv
package ivr_pkg;
   localparam int unsigned WORD_W   = 64;
   localparam int unsigned IDX_W    = 6;
   localparam int unsigned BUSY_BIT = 5;
   localparam int unsigned N_WORDS  = 3;

   localparam logic [7:0] SP_DISPATCH = 8'h48;
   localparam logic [7:0] SP_RECEIVE  = 8'h49;
   localparam logic [7:0] SP_INCOMING = 8'h7F;

   localparam logic [4:0]        WORD_TAG  = 5'h1F;
   localparam logic [WORD_W-1:0] BUSY_MASK = WORD_W'(1) << BUSY_BIT;

   typedef struct packed {
      logic             valid;
      logic [IDX_W-1:0] idx;
   } vec_sel_t;

   typedef enum logic [1:0] {
      EV_NONE,
      EV_STORE,
      EV_FALL,
      EV_RAISE
   } rx_event_e;
endpackage

// File: rtl/ivr_edge_detect.sv
module ivr_edge_detect #(
   parameter int unsigned N = 48
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] lvl,
   output logic [N-1:0] rise,
   output logic         fall_any
);
   logic [N-1:0] prev_q;
   logic [N-1:0] fall;

   for (genvar g = 0; g < N; g++) begin : g_line
      always_ff @(posedge clk) begin
         if (!rst_n) prev_q[g] <= 1'b0;
         else        prev_q[g] <= lvl[g];
      end
      assign rise[g] = lvl[g] & ~prev_q[g];
      assign fall[g] = prev_q[g] & ~lvl[g];
   end

   assign fall_any = |fall;
endmodule

// File: rtl/ivr_lowest_sel.sv
module ivr_lowest_sel #(
   parameter int unsigned N = 48
) (
   input  logic [N-1:0]     req,
   output ivr_pkg::vec_sel_t sel
);
   import ivr_pkg::*;

   always_comb begin
      logic found;
      found   = 1'b0;
      sel.idx = '0;
      for (int i = 0; i < N; i++) begin
         if (req[i] && !found) begin
            sel.idx = IDX_W'(i);
            found   = 1'b1;
         end
      end
      sel.valid = found;
   end
endmodule

// File: rtl/ivr_rx_regs.sv
module ivr_rx_regs #(
   parameter int unsigned          PIL_W     = 16,
   parameter int unsigned          PIL_BIT   = 5,
   parameter int unsigned          TRAP_W    = 9,
   parameter logic [TRAP_W-1:0]    TRAP_IVEC = 9'h060
) (
   input  logic                                        clk,
   input  logic                                        rst_n,
   input  ivr_pkg::vec_sel_t                           raise,
   input  logic                                        fall_any,
   input  logic                                        st_en,
   input  logic [ivr_pkg::WORD_W-1:0]                  st_data,
   output logic [ivr_pkg::WORD_W-1:0]                  status_q,
   output logic [ivr_pkg::N_WORDS-1:0][ivr_pkg::WORD_W-1:0] words_q,
   output logic                                        irq_q,
   output logic [PIL_W-1:0]                            pil,
   output logic [TRAP_W-1:0]                           trap_q
);
   import ivr_pkg::*;

   localparam int unsigned PAD_W = WORD_W - IDX_W - 5;

   rx_event_e ev;
   logic      pil_q;

   always_comb begin
      if (raise.valid)   ev = EV_RAISE;
      else if (fall_any) ev = EV_FALL;
      else if (st_en)    ev = EV_STORE;
      else               ev = EV_NONE;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         status_q <= '0;
         irq_q    <= 1'b0;
         pil_q    <= 1'b0;
         trap_q   <= '0;
      end else begin
         unique case (ev)
            EV_RAISE: begin
               status_q <= status_q | BUSY_MASK;
               irq_q    <= 1'b1;
               pil_q    <= 1'b1;
               trap_q   <= TRAP_IVEC;
            end
            EV_FALL: begin
               status_q <= status_q & ~BUSY_MASK;
               irq_q    <= 1'b0;
               pil_q    <= 1'b0;
            end
            EV_STORE: status_q <= st_data & BUSY_MASK;
            default: ;
         endcase
      end
   end

   for (genvar w = 0; w < N_WORDS; w++) begin : g_word
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            words_q[w] <= '0;
         end else if (ev == EV_RAISE) begin
            if (w == 0) words_q[w] <= {{PAD_W{1'b0}}, WORD_TAG, raise.idx};
            else        words_q[w] <= '0;
         end
      end
   end

   for (genvar b = 0; b < PIL_W; b++) begin : g_pil
      if (b == PIL_BIT) begin : g_live
         assign pil[b] = pil_q;
      end else begin : g_tied
         assign pil[b] = 1'b0;
      end
   end
endmodule

// File: rtl/ivr_asi_port.sv
module ivr_asi_port #(
   parameter int unsigned ADDR_W = 16
) (
   input  logic                                             asi_valid,
   input  logic                                             asi_we,
   input  logic [7:0]                                       asi_space,
   input  logic [ADDR_W-1:0]                                asi_addr,
   input  logic [ivr_pkg::WORD_W-1:0]                       asi_wdata,
   input  logic [ivr_pkg::WORD_W-1:0]                       status_q,
   input  logic [ivr_pkg::N_WORDS-1:0][ivr_pkg::WORD_W-1:0] words_q,
   output logic [ivr_pkg::WORD_W-1:0]                       asi_rdata,
   output logic                                             st_en,
   output logic [ivr_pkg::WORD_W-1:0]                       st_data
);
   import ivr_pkg::*;

   logic [1:0] word_idx;
   logic       rd_en;

   assign word_idx = 2'((asi_addr >> 4) & ADDR_W'(3));
   assign rd_en    = asi_valid & ~asi_we;
   assign st_en    = asi_valid & asi_we & (asi_space == SP_RECEIVE);
   assign st_data  = asi_wdata;

   always_comb begin
      asi_rdata = '0;
      if (rd_en) begin
         unique case (asi_space)
            SP_RECEIVE:  asi_rdata = status_q;
            SP_INCOMING: begin
               if (word_idx < 2'(N_WORDS)) asi_rdata = words_q[word_idx];
            end
            SP_DISPATCH: asi_rdata = '0;
            default:     asi_rdata = '0;
         endcase
      end
   end
endmodule

// File: rtl/intr_vec_receiver.sv
module intr_vec_receiver #(
   parameter int unsigned       NUM_VEC   = 48,
   parameter int unsigned       ADDR_W    = 16,
   parameter int unsigned       PIL_W     = 16,
   parameter int unsigned       PIL_BIT   = 5,
   parameter int unsigned       TRAP_W    = 9,
   parameter logic [TRAP_W-1:0] TRAP_IVEC = 9'h060
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [NUM_VEC-1:0]         vec_lvl,
   input  logic                       asi_valid,
   input  logic                       asi_we,
   input  logic [7:0]                 asi_space,
   input  logic [ADDR_W-1:0]          asi_addr,
   input  logic [63:0]                asi_wdata,
   output logic [63:0]                asi_rdata,
   output logic                       irq_req,
   output logic [PIL_W-1:0]           pil_level,
   output logic [TRAP_W-1:0]          trap_type
);
   import ivr_pkg::*;

   if (NUM_VEC < 1 || NUM_VEC > (1 << IDX_W)) begin : g_bad_num
      $error("NUM_VEC must lie in 1..64");
   end
   if (ADDR_W < 6) begin : g_bad_addr
      $error("ADDR_W must be at least 6");
   end
   if (PIL_BIT >= PIL_W) begin : g_bad_pil
      $error("PIL_BIT must be below PIL_W");
   end

   logic [NUM_VEC-1:0]               rise;
   logic                             fall_any;
   vec_sel_t                         raise;
   logic                             st_en;
   logic [WORD_W-1:0]                st_data;
   logic [WORD_W-1:0]                status_q;
   logic [N_WORDS-1:0][WORD_W-1:0]   words_q;
   logic [WORD_W-1:0]                word0_q;

   assign word0_q = words_q[0];

   ivr_edge_detect #(.N(NUM_VEC)) u_edge (
      .clk      (clk),
      .rst_n    (rst_n),
      .lvl      (vec_lvl),
      .rise     (rise),
      .fall_any (fall_any)
   );

   ivr_lowest_sel #(.N(NUM_VEC)) u_sel (
      .req (rise),
      .sel (raise)
   );

   ivr_asi_port #(.ADDR_W(ADDR_W)) u_port (
      .asi_valid (asi_valid),
      .asi_we    (asi_we),
      .asi_space (asi_space),
      .asi_addr  (asi_addr),
      .asi_wdata (asi_wdata),
      .status_q  (status_q),
      .words_q   (words_q),
      .asi_rdata (asi_rdata),
      .st_en     (st_en),
      .st_data   (st_data)
   );

   ivr_rx_regs #(
      .PIL_W     (PIL_W),
      .PIL_BIT   (PIL_BIT),
      .TRAP_W    (TRAP_W),
      .TRAP_IVEC (TRAP_IVEC)
   ) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .raise    (raise),
      .fall_any (fall_any),
      .st_en    (st_en),
      .st_data  (st_data),
      .status_q (status_q),
      .words_q  (words_q),
      .irq_q    (irq_req),
      .pil      (pil_level),
      .trap_q   (trap_type)
   );
endmodule

// File: rtl/ivr_checker.sv
module ivr_checker #(
   parameter int unsigned       NUM_VEC   = 48,
   parameter int unsigned       PIL_W     = 16,
   parameter int unsigned       PIL_BIT   = 5,
   parameter int unsigned       TRAP_W    = 9,
   parameter logic [TRAP_W-1:0] TRAP_IVEC = 9'h060
) (
   input logic               clk,
   input logic               rst_n,
   input logic [NUM_VEC-1:0] vec_lvl,
   input logic               asi_valid,
   input logic               asi_we,
   input logic [7:0]         asi_space,
   input logic [63:0]        asi_wdata,
   input logic [63:0]        asi_rdata,
   input logic               irq_req,
   input logic [PIL_W-1:0]   pil_level,
   input logic [TRAP_W-1:0]  trap_type,
   input logic [63:0]        status_q,
   input logic [63:0]        word0_q
);
   logic [NUM_VEC-1:0] shadow_q;
   logic               up, down, store;

   always_ff @(posedge clk) begin
      if (!rst_n) shadow_q <= '0;
      else        shadow_q <= vec_lvl;
   end

   assign up    = |(vec_lvl & ~shadow_q);
   assign down  = |(shadow_q & ~vec_lvl);
   assign store = asi_valid & asi_we & (asi_space == 8'h49);

   // R2
   raise_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
      up |=> status_q[5] && word0_q[10:6] == 5'h1F && word0_q[63:11] == '0);

   // R3
   raise_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
      up |=> irq_req && pil_level[PIL_BIT] && trap_type == TRAP_IVEC);

   // R3
   pil_other_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(pil_level) == (irq_req ? 1 : 0));

   // R6
   fall_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      down && !up |=> !irq_req && !status_q[5] && $stable(word0_q));

   // R8
   store_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
      store && !up && !down |=> status_q == ($past(asi_wdata) & 64'h20));

   // R10
   dispatch_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      asi_valid && !asi_we && asi_space == 8'h48 |-> asi_rdata == '0);

   // R11
   hold_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !up && !down |=> $stable(irq_req));
endmodule

bind intr_vec_receiver ivr_checker #(
   .NUM_VEC   (NUM_VEC),
   .PIL_W     (PIL_W),
   .PIL_BIT   (PIL_BIT),
   .TRAP_W    (TRAP_W),
   .TRAP_IVEC (TRAP_IVEC)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .vec_lvl   (vec_lvl),
   .asi_valid (asi_valid),
   .asi_we    (asi_we),
   .asi_space (asi_space),
   .asi_wdata (asi_wdata),
   .asi_rdata (asi_rdata),
   .irq_req   (irq_req),
   .pil_level (pil_level),
   .trap_type (trap_type),
   .status_q  (status_q),
   .word0_q   (word0_q)
);

// File: tb/tb_intr_vec_receiver.sv
module tb_intr_vec_receiver;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [47:0] vec_lvl = '0;
   logic        asi_valid = 1'b0;
   logic        asi_we = 1'b0;
   logic [7:0]  asi_space = '0;
   logic [15:0] asi_addr = '0;
   logic [63:0] asi_wdata = '0;
   logic [63:0] asi_rdata;
   logic        irq_req;
   logic [15:0] pil_level;
   logic [8:0]  trap_type;

   int checks = 0;
   int errors = 0;

   always #5 clk = ~clk;

   intr_vec_receiver dut (
      .clk(clk), .rst_n(rst_n), .vec_lvl(vec_lvl),
      .asi_valid(asi_valid), .asi_we(asi_we), .asi_space(asi_space),
      .asi_addr(asi_addr), .asi_wdata(asi_wdata), .asi_rdata(asi_rdata),
      .irq_req(irq_req), .pil_level(pil_level), .trap_type(trap_type)
   );

   typedef struct packed {
      logic [47:0] vec;
      logic [63:0] status;
      logic [11:0] word0;
      logic        irq;
   } row_t;

   localparam int NROWS = 11;
   localparam row_t TBL [NROWS] = '{
      '{48'h0,            64'h0,  12'h000, 1'b0},
      '{48'h8,            64'h20, 12'h7C3, 1'b1},
      '{48'h408,          64'h20, 12'h7CA, 1'b1},
      '{48'h400,          64'h0,  12'h7CA, 1'b0},
      '{48'h800000100400, 64'h20, 12'h7D4, 1'b1},
      '{48'h0,            64'h0,  12'h7D4, 1'b0},
      '{48'h1,            64'h20, 12'h7C0, 1'b1},
      '{48'h1,            64'h20, 12'h7C0, 1'b1},
      '{48'h3,            64'h20, 12'h7C1, 1'b1},
      '{48'h4,            64'h20, 12'h7C2, 1'b1},
      '{48'h0,            64'h0,  12'h7C2, 1'b0}
   };

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic rd(input logic [7:0] sp, input logic [15:0] ad, output logic [63:0] d);
      asi_valid = 1'b1; asi_we = 1'b0; asi_space = sp; asi_addr = ad;
      #1 d = asi_rdata;
      asi_valid = 1'b0; asi_space = '0; asi_addr = '0;
   endtask

   // called just after a falling edge; applies inputs for exactly one rising edge
   task automatic step(input logic [47:0] v, input logic st, input logic [7:0] sp,
                       input logic [15:0] ad, input logic [63:0] wd);
      vec_lvl = v;
      asi_valid = st; asi_we = st; asi_space = sp; asi_addr = ad; asi_wdata = wd;
      @(posedge clk);
      @(negedge clk);
      asi_valid = 1'b0; asi_we = 1'b0; asi_space = '0; asi_addr = '0; asi_wdata = '0;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      logic [63:0] d;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      rd(8'h49, 16'h0, d);  check("R1 status", d, 64'h0);
      rd(8'h7F, 16'h0, d);  check("R1 word0", d, 64'h0);
      check("R1 irq", {63'b0, irq_req}, 64'h0);
      check("R1 pil", {48'b0, pil_level}, 64'h0);
      check("R1 trap", {55'b0, trap_type}, 64'h0);

      // R2 R4 R5 R6 R7 vector table walk
      for (int i = 0; i < NROWS; i++) begin
         step(TBL[i].vec, 1'b0, 8'h0, 16'h0, 64'h0);
         rd(8'h49, 16'h0, d);  check($sformatf("R7 R6 status row %0d", i), d, TBL[i].status);
         rd(8'h7F, 16'h0, d);  check($sformatf("R2 R4 R5 word0 row %0d", i), d, {52'b0, TBL[i].word0});
         check($sformatf("R3 R6 irq row %0d", i), {63'b0, irq_req}, {63'b0, TBL[i].irq});
         check($sformatf("R3 pil row %0d", i), {48'b0, pil_level}, {59'b0, TBL[i].irq, 5'b0});
         if (TBL[i].irq) check($sformatf("R3 trap row %0d", i), {55'b0, trap_type}, 64'h60);
      end

      // R9 word select
      rd(8'h7F, 16'h10, d); check("R9 word1", d, 64'h0);
      rd(8'h7F, 16'h20, d); check("R9 word2", d, 64'h0);
      rd(8'h7F, 16'h30, d); check("R9 index3", d, 64'h0);
      rd(8'h7F, 16'h40, d); check("R9 index wraps to 0", d, 64'h7C2);
      check("R3 trap held", {55'b0, trap_type}, 64'h60);

      // R8 store masking
      step(48'h0, 1'b1, 8'h49, 16'h0, 64'hFFFF_FFFF_FFFF_FFFF);
      rd(8'h49, 16'h0, d);  check("R8 store all ones", d, 64'h20);
      check("R8 store leaves irq", {63'b0, irq_req}, 64'h0);
      step(48'h0, 1'b1, 8'h49, 16'h0, 64'hFFFF_FFFF_FFFF_FFDF);
      rd(8'h49, 16'h0, d);  check("R8 store without bit5", d, 64'h0);

      // R10 ignored stores and zero spaces
      step(48'h0, 1'b1, 8'h7F, 16'h0, 64'h1234);
      step(48'h0, 1'b1, 8'h48, 16'h0, 64'h20);
      rd(8'h7F, 16'h0, d);  check("R10 word0 after stores", d, 64'h7C2);
      rd(8'h49, 16'h0, d);  check("R10 status after stores", d, 64'h0);
      rd(8'h48, 16'h0, d);  check("R10 dispatch read", d, 64'h0);
      rd(8'h12, 16'h0, d);  check("R10 other space", d, 64'h0);

      // R11 held level does not retrigger
      step(48'h20, 1'b0, 8'h0, 16'h0, 64'h0);
      rd(8'h7F, 16'h0, d);  check("R2 word0 line5", d, 64'h7C5);
      step(48'h20, 1'b1, 8'h49, 16'h0, 64'h0);
      repeat (3) step(48'h20, 1'b0, 8'h0, 16'h0, 64'h0);
      rd(8'h49, 16'h0, d);  check("R11 status stays clear", d, 64'h0);
      check("R11 irq stays high", {63'b0, irq_req}, 64'h1);

      // R8 rise beats store in same cycle
      step(48'h220, 1'b1, 8'h49, 16'h0, 64'h0);
      rd(8'h49, 16'h0, d);  check("R8 rise beats store", d, 64'h20);
      rd(8'h7F, 16'h0, d);  check("R5 word0 line9", d, 64'h7C9);

      // R8 fall beats store in same cycle
      step(48'h0, 1'b1, 8'h49, 16'h0, 64'hFF);
      rd(8'h49, 16'h0, d);  check("R8 fall beats store", d, 64'h0);
      check("R6 irq cleared", {63'b0, irq_req}, 64'h0);

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule